// File: doc/BRIEF.md
# Registered NOR-NOR Logic Array

This block evaluates a set of Boolean functions of one input vector, all in parallel, as a two-level NOR-NOR array placed between an input register and an output register. Each clock edge samples the input vector. Every captured bit drives two literal lines, one with the bit's true value and one with its complement. A first NOR plane builds product-style term lines from chosen literals. A second NOR plane combines chosen term lines into the output functions. All outputs are loaded into the output register on the same edge.

Both connection matrices (the personality) are elaboration-time parameters. Changing the control function only requires a new pair of mask values at instantiation. It needs no extra file and no change to the RTL. A result appears two clock edges after its input is presented. A new input may be presented every cycle.

Top module: `nor_pla`

## Requirements
- R1: The input vector `in_i` is captured in an input register on each rising clock edge, and no logic acts on `in_i` directly.
- R2: For captured bit i, literal line 2i carries the bit's true value and literal line 2i+1 carries its complement.
- R3: Term line t is the NOR of the literal lines k for which bit t*2*N_IN+k of `TERM_MASK` is set. A term line with no enabled literal is 1.
- R4: Output j is the NOR of the term lines t for which bit j*N_TERM+t of `OUT_MASK` is set. An output with no enabled term line is 1.
- R5: All output functions are loaded into the output register on the same edge, and `out_o` is driven only by that register.
- R6: A value held on `in_i` before rising edge k appears at `out_o` after edge k+1, and not after edge k alone. Back-to-back inputs give back-to-back results.
- R7: Asserting `rst_ni` low clears both registers at once, so `out_o` is 0. After release, the first edge shows the function of an all-zero input, and the second edge shows the function of the applied input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | N_IN | Input vector to the array |
| out_o | output | N_OUT | Registered output functions |

## Verification
The bench runs every input combination of a small personality. That personality has a two-term function, a single-literal function, an output driven by an empty term, and an output with no enabled term. Together these cover literal polarity, each NOR plane, and both empty-mask rules. A long random stream, with a new vector every cycle, is compared against a reference sum-of-products model two edges later. This catches any extra or missing stage in the pipeline. Directed tests apply one vector and check it after one edge and after two. They also release reset with a nonzero input held, which shows whether the input register was cleared.

// File: rtl/nor_pla_pkg.sv
package nor_pla_pkg;

  function automatic int unsigned lit_count(input int unsigned n_in);
    return 2 * n_in;
  endfunction

  function automatic int unsigned mask_bits(input int unsigned rows, input int unsigned cols);
    return rows * cols;
  endfunction

endpackage

// File: rtl/pla_literal_gen.sv
module pla_literal_gen #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned N_LIT = nor_pla_pkg::lit_count(N_IN)
) (
  input  logic [N_IN-1:0]  bits_i,
  output logic [N_LIT-1:0] lit_o
);

  // even line: true value, odd line: complement
  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    assign lit_o[2*i]   = bits_i[i];
    assign lit_o[2*i+1] = ~bits_i[i];
  end

endmodule

// File: rtl/pla_nor_plane.sv
module pla_nor_plane #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_ROW = 8,
  parameter logic [N_ROW*N_SRC-1:0] MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_ROW-1:0] row_o
);

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    localparam logic [N_SRC-1:0] ROW_MASK = MASK[r*N_SRC +: N_SRC];
    assign row_o[r] = ~|(src_i & ROW_MASK);

    if (ROW_MASK == '0) begin : g_empty
      // R3 in the term plane, R4 in the output plane
      p_empty_row_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_o[r] == 1'b1)
        else $error("empty row %0d not held high", r);
    end
  end

endmodule

// File: rtl/nor_pla.sv
module nor_pla #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 4,
  parameter logic [N_TERM*2*N_IN-1:0] TERM_MASK = 64'h0030_00c0_0a05_4112,
  parameter logic [N_OUT*N_TERM-1:0]  OUT_MASK  = 32'h00c0_300f
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);

  localparam int unsigned N_LIT = nor_pla_pkg::lit_count(N_IN);

  logic [N_IN-1:0]   in_q;
  logic [N_LIT-1:0]  lit;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  fn;
  logic [N_OUT-1:0]  out_q;
  logic              primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q     <= '0;
      out_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      in_q     <= in_i;
      out_q    <= fn;
      primed_q <= 1'b1;
    end
  end

  pla_literal_gen #(.N_IN(N_IN)) u_lit (
    .bits_i (in_q),
    .lit_o  (lit)
  );

  pla_nor_plane #(.N_SRC(N_LIT), .N_ROW(N_TERM), .MASK(TERM_MASK)) u_term_plane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (lit),
    .row_o  (term)
  );

  pla_nor_plane #(.N_SRC(N_TERM), .N_ROW(N_OUT), .MASK(OUT_MASK)) u_out_plane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (term),
    .row_o  (fn)
  );

  assign out_o = out_q;

  p_in_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> in_q == $past(in_i))
    else $error("input register missed its sample");

  // steady captured input leaves the output register steady one edge later
  p_out_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && in_q == $past(in_q)) |=> $stable(out_o))
    else $error("output moved with steady input");

  p_reset_clear_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (out_o == '0 && in_q == '0))
    else $error("registers not cleared in reset");

endmodule

// File: tb/tb_nor_pla.sv
module tb_nor_pla;

  localparam int unsigned NI = 3;
  localparam int unsigned NT = 4;
  localparam int unsigned NO = 4;
  // t0 = ~x0&~x1, t1 = x0&~x2, t2 = 1 (empty), t3 = x2
  localparam logic [NT*2*NI-1:0] TM = {6'b100000, 6'b000000, 6'b010010, 6'b000101};
  // o0 = ~(t0|t1), o1 = ~t3, o2 = ~t2 = 0, o3 empty = 1
  localparam logic [NO*NT-1:0] OM = {4'b0000, 4'b0100, 4'b1000, 4'b0011};

  typedef struct packed { logic [NI-1:0] vin; logic [NO-1:0] vexp; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'b000, 4'b1010}, '{3'b001, 4'b1010}, '{3'b010, 4'b1011}, '{3'b011, 4'b1010},
    '{3'b100, 4'b1000}, '{3'b101, 4'b1001}, '{3'b110, 4'b1001}, '{3'b111, 4'b1001}};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  nor_pla #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO), .TERM_MASK(TM), .OUT_MASK(OM)) dut (
    .clk_i (clk), .rst_ni (rst_n), .in_i (din), .out_o (dout));

  function automatic logic [NO-1:0] ref_model(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    for (int j = 0; j < NO; j++) begin
      r[j] = 1'b1;
      for (int t = 0; t < NT; t++) begin
        logic prod;
        prod = 1'b1;
        for (int i = 0; i < NI; i++) begin
          if (TM[t*2*NI + 2*i] && x[i]) prod = 1'b0;
          if (TM[t*2*NI + 2*i + 1] && !x[i]) prod = 1'b0;
        end
        if (OM[j*NT + t] && prod) r[j] = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NI-1:0] hist [2];
    #1 rst_n = 1'b0;
    din = 3'b101;
    repeat (2) @(negedge clk);
    check("R7 reset clears output", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first edge shows f(0)", dout, 4'b1010);
    @(negedge clk);
    check("R7 second edge shows f(in)", dout, 4'b1001);

    // R2 R3 R4 exhaustive table, also against reference model
    foreach (VECS[v]) begin
      din = VECS[v].vin;
      repeat (2) @(negedge clk);
      check("R2/R3/R4 table", dout, VECS[v].vexp);
      check("R4 table vs model", dout, ref_model(VECS[v].vin));
    end

    // R6 latency: one edge is not enough
    din = 3'b100;
    repeat (2) @(negedge clk);
    din = 3'b010;
    @(negedge clk);
    check("R6 one edge holds old", dout, 4'b1000);
    @(negedge clk);
    check("R6 two edges shows new", dout, 4'b1011);

    // R5 R6 streaming random vectors, one per cycle
    hist[0] = $urandom_range(7);
    din = hist[0];
    @(negedge clk);
    hist[1] = $urandom_range(7);
    din = hist[1];
    for (int k = 0; k < 300; k++) begin
      logic [NI-1:0] nv;
      @(negedge clk);
      check("R5/R6 stream", dout, ref_model(hist[0]));
      nv = NI'($urandom_range(7));
      hist[0] = hist[1];
      hist[1] = nv;
      din = nv;
    end

    // R7 mid-run reset
    din = 3'b010;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 async clear", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 recapture after reset", dout, 4'b1011);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule